// File: doc/BRIEF.md
# Clock-Enabled Iterative AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key using AES-128 in electronic codebook form. It works iteratively. One round is computed per enabled clock, and each round key is derived in the same cycle as the round that uses it, so no key schedule is stored.

Every register in the core advances only when the clock-enable input `ce` is high. The number of raw clocks an encryption takes therefore depends on the enable pattern. Several copies of the core can share one clock and take turns through staggered enables, while each copy still needs exactly eleven enabled cycles per block. That is one cycle to load the block and ten cycles for the rounds.

A caller pulses `start` with `ce` high while the core is idle. It then waits for `done` and reads `ciphertext`, which stays steady until the next accepted start.

Top module: `aes_ce_core`

## Requirements
- R1: After reset `busy` and `done` are low and `ciphertext` is all zeros.
- R2: When `start` and `ce` are both high at a clock edge while `busy` is low, the core loads the block. This includes the edge at which `done` is still high. From that edge `busy` is high and `done` is low.
- R3: At any edge where `ce` is low, `busy`, `done`, `ciphertext` and all internal round state keep their values.
- R4: `done` rises, and `busy` falls, at the tenth `ce`-high edge after the loading edge.
- R5: Once raised, `done` stays high through edges with `ce` low and clears at the next edge with `ce` high.
- R6: `ciphertext` equals the AES-128 encryption of `plaintext` under `key`, as sampled at the loading edge. Byte 0 occupies bits 127:120. Byte index 4c+r holds row r of column c. For example, key 000102..0f with plaintext 00112233..eeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R7: A `start` pulse while `busy` is high is ignored, and so are changes on `plaintext` or `key` at that time. The block in flight completes with its original result.
- R8: A `start` pulse while `ce` is low is ignored, and `busy` stays low.
- R9: While the core is idle, `ciphertext` holds its value until the next accepted start, whatever `plaintext` and `key` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable qualifying every register update |
| start | input | 1 | Request to load a new block |
| plaintext | input | 128 | Block to encrypt, sampled at the loading edge |
| key | input | 128 | Cipher key, sampled at the loading edge |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | Result ready pulse, one enabled cycle long |
| ciphertext | output | 128 | Encrypted block, valid from `done` until the next load |

## Verification
The assertions assume that `ce` and `start` are known at every edge after reset. They also assume that `plaintext` and `key` matter only at the loading edge, so none of them constrains the data inputs. The bench drives the enable in several ways: always high, alternating, and pseudo-random. It also scrambles the data inputs and raises `start` at moments that must be refused. This means every hold and ignore property is exercised against inputs that actually change.

// File: rtl/aes_ce_pkg.sv
package aes_ce_pkg;
  localparam int BLK_W      = 128;
  localparam int WORD_W     = 32;
  localparam int NUM_ROUNDS = 10;
  localparam int RND_W      = $clog2(NUM_ROUNDS + 1);

  typedef logic [7:0]        byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [RND_W-1:0]  rnd_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc = 8'h00;
    byte_t sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // inverse as a^254 by square-and-multiply; zero maps to zero
  function automatic byte_t gf_inv(input byte_t a);
    byte_t res = 8'h01;
    byte_t pw  = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) res = gf_mul(res, pw);
      pw = gf_mul(pw, pw);
    end
    return res;
  endfunction

  function automatic byte_t rotl8(input byte_t x, input int n);
    logic [15:0] d;
    d = {x, x};
    return d[15-n -: 8];
  endfunction

  function automatic byte_t sbox_byte(input byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // round constant for round r (1-based): x^(r-1)
  function automatic byte_t rcon_of(input rnd_t r);
    byte_t c = 8'h01;
    for (int i = 1; i < NUM_ROUNDS; i++)
      if (i < int'(r)) c = xtime(c);
    return c;
  endfunction

  function automatic word_t mix_col(input word_t w);
    byte_t a0, a1, a2, a3;
    a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction
endpackage

// File: rtl/aes_sub_shift.sv
module aes_sub_shift
  import aes_ce_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  // byte index 4c+r = row r, column c; row r rotates left by r columns
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = 4 * c + r;
      localparam int SRC = 4 * ((c + r) % 4) + r;
      assign dout[BLK_W-1-8*DST -: 8] = sbox_byte(din[BLK_W-1-8*SRC -: 8]);
    end
  end
endmodule

// File: rtl/aes_round_comb.sv
module aes_round_comb
  import aes_ce_pkg::*;
(
  input  logic [BLK_W-1:0] state_in,
  input  logic [BLK_W-1:0] round_key,
  input  logic             final_round,
  output logic [BLK_W-1:0] state_out
);
  localparam int NCOL = BLK_W / WORD_W;

  logic [BLK_W-1:0] shifted;
  logic [BLK_W-1:0] mixed;

  aes_sub_shift u_sub_shift (
    .din  (state_in),
    .dout (shifted)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_mix
    assign mixed[BLK_W-1-WORD_W*c -: WORD_W] = mix_col(shifted[BLK_W-1-WORD_W*c -: WORD_W]);
  end

  assign state_out = (final_round ? shifted : mixed) ^ round_key;
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_ce_pkg::*;
(
  input  logic [BLK_W-1:0] key_in,
  input  logic [7:0]       rcon,
  output logic [BLK_W-1:0] key_out
);
  localparam int NWORD = BLK_W / WORD_W;

  word_t last_w, rot_w, sub_w, mix_t;
  word_t w_new [NWORD];

  assign last_w = key_in[WORD_W-1:0];
  assign rot_w  = {last_w[23:0], last_w[31:24]};

  for (genvar b = 0; b < 4; b++) begin : g_subword
    assign sub_w[31-8*b -: 8] = sbox_byte(rot_w[31-8*b -: 8]);
  end

  assign mix_t = sub_w ^ {rcon, 24'h000000};

  for (genvar w = 0; w < NWORD; w++) begin : g_words
    if (w == 0) begin : g_first
      assign w_new[w] = key_in[BLK_W-1 -: WORD_W] ^ mix_t;
    end else begin : g_rest
      assign w_new[w] = key_in[BLK_W-1-WORD_W*w -: WORD_W] ^ w_new[w-1];
    end
    assign key_out[BLK_W-1-WORD_W*w -: WORD_W] = w_new[w];
  end
endmodule

// File: rtl/aes_ce_ctrl.sv
module aes_ce_ctrl
  import aes_ce_pkg::*;
#(
  parameter int N_ROUNDS = NUM_ROUNDS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output rnd_t       round_q,
  output logic       accept,
  output logic       step,
  output logic       last_step
);
  assign accept    = ce & start & ~busy;
  assign step      = ce & busy;
  assign last_step = step & (round_q == RND_W'(N_ROUNDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      round_q <= '0;
    end else if (ce) begin
      done <= last_step;
      if (accept) begin
        busy    <= 1'b1;
        round_q <= RND_W'(1);
      end else if (last_step) begin
        busy    <= 1'b0;
        round_q <= '0;
      end else if (step) begin
        round_q <= round_q + RND_W'(1);
      end
    end
  end

  // R2
  a_r2_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !done && round_q == RND_W'(1));
  // R3
  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(busy) && $stable(done) && $stable(round_q));
  // R4
  a_r4_last_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done && !busy);
  a_r4_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_step));
  a_r4_round_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (round_q >= RND_W'(1) && round_q <= RND_W'(N_ROUNDS)));
  // R5
  a_r5_done_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ce) |=> !done);
  // R7
  a_r7_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);
  // R8
  a_r8_idle_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ce) |=> !busy);
endmodule

// File: rtl/aes_ce_core.sv
module aes_ce_core
  import aes_ce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             start,
  input  logic [127:0]     plaintext,
  input  logic [127:0]     key,
  output logic             busy,
  output logic             done,
  output logic [127:0]     ciphertext
);
  blk_t  state_q, rkey_q;
  blk_t  state_nx, rkey_nx;
  rnd_t  round_q;
  logic  accept, step, last_step;
  logic  final_round;
  byte_t rcon;

  aes_ce_ctrl #(.N_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .round_q   (round_q),
    .accept    (accept),
    .step      (step),
    .last_step (last_step)
  );

  assign rcon        = rcon_of(round_q);
  assign final_round = (round_q == RND_W'(NUM_ROUNDS));

  aes_key_step u_key_step (
    .key_in  (rkey_q),
    .rcon    (rcon),
    .key_out (rkey_nx)
  );

  aes_round_comb u_round (
    .state_in    (state_q),
    .round_key   (rkey_nx),
    .final_round (final_round),
    .state_out   (state_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      rkey_q  <= '0;
    end else if (accept) begin
      state_q <= plaintext ^ key;
      rkey_q  <= key;
    end else if (step) begin
      state_q <= state_nx;
      rkey_q  <= rkey_nx;
    end
  end

  assign ciphertext = state_q;

  // R3
  a_r3_datapath_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(state_q) && $stable(rkey_q));
  // R9
  a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(ciphertext));
  // R7
  a_r7_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ce) |=> $stable(ciphertext));
endmodule

// File: tb/aes_ce_core_tb.sv
module aes_ce_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ce = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plaintext = '0;
  logic [127:0] key = '0;
  logic         busy, done;
  logic [127:0] ciphertext;

  int nchk = 0;
  int nfail = 0;
  logic [7:0]  sbt [256];
  logic [15:0] lfsr = 16'hace1;
  logic        tgl = 1'b0;

  aes_ce_core u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start),
    .plaintext(plaintext), .key(key),
    .busy(busy), .done(done), .ciphertext(ciphertext)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] m2(input logic [7:0] x);
    return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
  endfunction

  // substitution table from exp/log tables, generator 3
  task automatic build_sbox();
    logic [7:0] ex [256];
    int         lg [256];
    logic [7:0] inv, o;
    ex[0] = 8'h01;
    for (int i = 0; i < 255; i++) begin
      lg[ex[i]] = i;
      ex[i+1] = ex[i] ^ m2(ex[i]);
    end
    for (int a = 0; a < 256; a++) begin
      inv = (a == 0) ? 8'h00 : ex[(255 - lg[a]) % 255];
      for (int b = 0; b < 8; b++)
        o[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 8'h01) != 0;
      sbt[a] = o;
    end
  endtask

  function automatic logic [127:0] ref_aes(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] s [16];
    logic [7:0] w [16];
    logic [7:0] t [16];
    logic [7:0] rc, a0, a1, a2, a3;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127-8*i -: 8];
      s[i] = p[127-8*i -: 8] ^ w[i];
    end
    for (int rnd = 1; rnd <= 10; rnd++) begin
      w[0] = w[0] ^ sbt[w[13]] ^ rc;
      w[1] = w[1] ^ sbt[w[14]];
      w[2] = w[2] ^ sbt[w[15]];
      w[3] = w[3] ^ sbt[w[12]];
      for (int i = 4; i < 16; i++) w[i] = w[i] ^ w[i-4];
      rc = m2(rc);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          t[4*c+r] = sbt[s[4*((c+r)%4)+r]];
      if (rnd < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
          t[4*c]   = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
          t[4*c+1] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
          t[4*c+2] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
          t[4*c+3] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
        end
      end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ w[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic s);
    ce = c;
    start = s;
    @(negedge clk);
  endtask

  task automatic get_ce(input int mode, output logic c);
    if (mode == 0) c = 1'b1;
    else if (mode == 1) begin tgl = ~tgl; c = tgl; end
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = lfsr[0];
    end
  endtask

  // load, then run to done; poke >= 0 raises a refused start mid-flight
  task automatic run_op(input logic [127:0] p, input logic [127:0] k, input int mode,
                        input int poke, output logic [127:0] ct);
    int nen = 0, guard = 0;
    logic c, hold_bad = 1'b0, poked = 1'b0;
    logic [127:0] pc;
    logic pb, pd;
    plaintext = p; key = k;
    step(1'b1, 1'b1);
    chk(busy === 1'b1 && done === 1'b0, "R2 load", {busy, done}, 2'b10);
    while (done !== 1'b1 && guard < 400) begin
      get_ce(mode, c);
      pc = ciphertext; pb = busy; pd = done;
      if (nen == poke && !poked) begin
        poked = 1'b1;
        plaintext = ~p; key = ~k;
        step(1'b1, 1'b1);
        c = 1'b1;
        plaintext = p; key = k;
      end else begin
        step(c, 1'b0);
      end
      if (c) nen++;
      else if (ciphertext !== pc || busy !== pb || done !== pd) hold_bad = 1'b1;
      guard++;
    end
    chk(!hold_bad, "R3 hold with ce low", hold_bad, 0);
    chk(nen == 10 && busy === 1'b0, "R4 enabled rounds", nen, 10);
    ct = ciphertext;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step(1'b1, 1'b0);
    chk(busy === 1'b0 && done === 1'b0 && ciphertext === '0, "R1 reset", {busy, done, ciphertext}, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
  endtask

  task automatic t_kat();
    logic [127:0] ct;
    logic [127:0] k = 128'h000102030405060708090a0b0c0d0e0f;
    logic [127:0] p = 128'h00112233445566778899aabbccddeeff;
    logic [127:0] e = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    chk(ref_aes(k, p) === e, "R6 bench model", ref_aes(k, p), e);
    run_op(p, k, 0, -1, ct);
    chk(ct === e, "R6 known answer, ce high", ct, e);
  endtask

  task automatic t_done_pulse();
    logic [127:0] ct;
    logic [127:0] k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    logic [127:0] p = 128'h3243f6a8885a308d313198a2e0370734;
    logic [127:0] e = 128'h3925841d02dc09fbdc118597196a0b32;
    logic stay = 1'b1;
    run_op(p, k, 1, -1, ct);
    chk(ct === e, "R6 known answer, alternating ce", ct, e);
    repeat (3) begin
      step(1'b0, 1'b0);
      if (done !== 1'b1) stay = 1'b0;
    end
    chk(stay, "R5 done held while ce low", stay, 1);
    step(1'b1, 1'b0);
    chk(done === 1'b0, "R5 done cleared at enabled edge", done, 0);
    chk(ciphertext === e, "R9 result after done clears", ciphertext, e);
  endtask

  task automatic t_start_no_ce();
    logic [127:0] prev = ciphertext;
    logic ok = 1'b1;
    plaintext = 128'h1; key = 128'h2;
    repeat (5) begin
      step(1'b0, 1'b1);
      if (busy !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R8 start with ce low ignored", busy, 0);
    chk(ciphertext === prev, "R8 result untouched", ciphertext, prev);
    step(1'b0, 1'b0);
  endtask

  task automatic t_idle_hold();
    logic [127:0] prev = ciphertext;
    logic ok = 1'b1;
    logic c;
    for (int i = 0; i < 20; i++) begin
      plaintext = {$urandom, $urandom, $urandom, $urandom};
      key = {$urandom, $urandom, $urandom, $urandom};
      get_ce(2, c);
      step(c, 1'b0);
      if (ciphertext !== prev || busy !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R9 idle result holds", ciphertext, prev);
  endtask

  task automatic t_start_busy();
    logic [127:0] ct;
    logic [127:0] k = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    logic [127:0] p = 128'hfedcba98765432100123456789abcdef;
    run_op(p, k, 0, 4, ct);
    chk(ct === ref_aes(k, p), "R7 start while busy ignored", ct, ref_aes(k, p));
  endtask

  task automatic t_random_b2b();
    logic [127:0] ct, k, p;
    for (int i = 0; i < 4; i++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      run_op(p, k, 2, -1, ct);
      chk(ct === ref_aes(k, p), "R6 random block, random ce", ct, ref_aes(k, p));
    end
  endtask

  initial begin
    build_sbox();
    @(negedge clk);
    t_reset();
    t_kat();
    t_done_pulse();
    t_start_no_ce();
    t_idle_hold();
    t_start_busy();
    t_random_b2b();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule